// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block turns a free-running oscillator enable into a programmable periodic event, a square wave and a once-per-second tick. A prescaler first reduces the oscillator input to a common reference rate, chosen by a 3-bit base field for a high-frequency (4 MHz class), mid-frequency (1 MHz class) or low-frequency (32 kHz class) oscillator. A binary divider chain then counts reference ticks, and a 4-bit rate field picks the chain tap that produces the periodic event.

Every event sets a sticky periodic flag and toggles the square-wave output when that output is enabled. The interrupt request is the flag gated by its enable. Base codes other than the three oscillator choices hold the prescaler and chain at zero, so releasing the hold restarts the timing from a known phase. The once-per-second tick fires each time the full chain wraps. It feeds the time counter in the same clock domain.

Top module: `periodic_divider`

## Requirements
- R1: Out of reset per_flag_o, irq_o, sqw_o and sec_tick_o are all 0.
- R2: With base_sel_i = 2 (low-frequency base) and one oscillator tick per clock, rate codes 3 to 15 give one event every 2^(code-1) ticks. Code 3 is every 4 ticks and code 15 is every 16384 ticks.
- R3: With base 2, rate code 1 gives one event every 128 ticks and code 2 one every 256 ticks.
- R4: With base_sel_i = 0 the prescaler divides by 128, and with base_sel_i = 1 it divides by 32. Rate codes 1 and 2 then give one event every 1 and 2 reference ticks. Codes 3 to 15 give one every 2^(code-1) reference ticks.
- R5: base_sel_i values 3 to 7 hold the prescaler and chain at zero and produce no event and no second tick. After release, the first event comes exactly one full period later.
- R6: Rate code 0 produces no event.
- R7: Each event sets per_flag_o on the following clock edge, whatever per_ie_i is. A flag_clr_i pulse clears the flag. A new event in the same cycle wins over the clear.
- R8: irq_o is high exactly when per_flag_o and per_ie_i are both high.
- R9: With sqw_en_i high and a nonzero rate code, sqw_o toggles on every event, so its period is two event periods. It is 0 whenever sqw_en_i is low or the rate code is 0.
- R10: sec_tick_o is a one-cycle pulse. The first one comes 32768 reference ticks after release from hold.
- R11: When osc_tick_i is low, the divider does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| osc_tick_i | input | 1 | One-cycle enable per oscillator period |
| base_sel_i | input | 3 | Oscillator base: 0 high, 1 mid, 2 low, others hold |
| rate_sel_i | input | 4 | Periodic rate code, 0 = off |
| per_ie_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave output enable |
| flag_clr_i | input | 1 | Clears the periodic flag (status read) |
| per_flag_o | output | 1 | Sticky periodic event flag |
| irq_o | output | 1 | Periodic interrupt request |
| sqw_o | output | 1 | Square-wave output |
| sec_tick_o | output | 1 | One-second tick pulse |

## Verification
Assertions check four properties on every cycle:
- the flag rises only after a chain event;
- the square wave rises only on an event and stays low while disabled;
- no event occurs while the hold base is selected;
- the interrupt never appears without its enable.

Only the bench scenarios can show the properties that depend on counts:
- the exact period of each rate code under each base;
- the remapping of codes 1 and 2;
- the full-period delay after release from hold;
- the one-second delay.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   localparam logic [2:0] BASE_HI  = 3'd0;
   localparam logic [2:0] BASE_MID = 3'd1;
   localparam logic [2:0] BASE_LO  = 3'd2;

   typedef struct packed {
      logic       valid;
      logic [3:0] idx;
   } tap_sel_t;

   function automatic logic base_holds(input logic [2:0] base);
      return (base != BASE_HI) && (base != BASE_MID) && (base != BASE_LO);
   endfunction

   // Chain tap (log2 of event period in reference ticks) for a rate code.
   function automatic tap_sel_t tap_of(input logic [2:0] base, input logic [3:0] code);
      tap_sel_t t;
      t.valid = (code != 4'd0);
      if (code == 4'd1)      t.idx = (base == BASE_LO) ? 4'd7 : 4'd0;
      else if (code == 4'd2) t.idx = (base == BASE_LO) ? 4'd8 : 4'd1;
      else if (code == 4'd0) t.idx = 4'd0;
      else                   t.idx = code - 4'd1;
      return t;
   endfunction

endpackage

// File: rtl/pdiv_prescale.sv
module pdiv_prescale #(
   parameter int PRE_HI_LOG2  = 7,
   parameter int PRE_MID_LOG2 = 5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       hold_i,
   input  logic       osc_tick_i,
   input  logic [2:0] base_sel_i,
   output logic       ref_en_o
);
   import pdiv_pkg::*;

   localparam logic [PRE_HI_LOG2-1:0] MASK_HI  = {PRE_HI_LOG2{1'b1}};
   localparam logic [PRE_HI_LOG2-1:0] MASK_MID = MASK_HI >> (PRE_HI_LOG2 - PRE_MID_LOG2);

   logic [PRE_HI_LOG2-1:0] pre_q;
   logic [PRE_HI_LOG2-1:0] mask;

   always_comb begin
      unique case (base_sel_i)
         BASE_HI:  mask = MASK_HI;
         BASE_MID: mask = MASK_MID;
         default:  mask = '0;
      endcase
   end

   assign ref_en_o = osc_tick_i && !hold_i && ((pre_q & mask) == mask);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || hold_i) pre_q <= '0;
      else if (osc_tick_i)   pre_q <= pre_q + 1'b1;
   end

   assert_ref_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osc_tick_i |-> !ref_en_o);

endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain #(
   parameter int SEC_LOG2 = 15
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       hold_i,
   input  logic       ref_en_i,
   input  logic       tap_valid_i,
   input  logic [3:0] tap_idx_i,
   output logic       event_o,
   output logic       sec_o
);
   logic [SEC_LOG2-1:0] chain_q;
   logic [SEC_LOG2:0]   carry;

   for (genvar k = 0; k <= SEC_LOG2; k++) begin : g_carry
      if (k == 0) begin : g_base
         assign carry[k] = 1'b1;
      end else begin : g_tap
         assign carry[k] = &chain_q[k-1:0];
      end
   end

   assign event_o = ref_en_i && tap_valid_i && carry[tap_idx_i];
   assign sec_o   = ref_en_i && carry[SEC_LOG2];

   always_ff @(posedge clk_i) begin
      if (!rst_ni || hold_i) chain_q <= '0;
      else if (ref_en_i)     chain_q <= chain_q + 1'b1;
   end

   assert_hold_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> (!event_o && !sec_o));

endmodule

// File: rtl/periodic_divider.sv
module periodic_divider #(
   parameter int PRE_HI_LOG2  = 7,
   parameter int PRE_MID_LOG2 = 5,
   parameter int SEC_LOG2     = 15
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       osc_tick_i,
   input  logic [2:0] base_sel_i,
   input  logic [3:0] rate_sel_i,
   input  logic       per_ie_i,
   input  logic       sqw_en_i,
   input  logic       flag_clr_i,
   output logic       per_flag_o,
   output logic       irq_o,
   output logic       sqw_o,
   output logic       sec_tick_o
);
   import pdiv_pkg::*;

   if (PRE_MID_LOG2 < 1 || PRE_HI_LOG2 <= PRE_MID_LOG2) begin : g_bad_pre
      $error("prescale widths must satisfy 0 < PRE_MID_LOG2 < PRE_HI_LOG2");
   end
   if (SEC_LOG2 < 15) begin : g_bad_sec
      $error("SEC_LOG2 must cover the slowest rate tap");
   end

   logic     hold;
   logic     ref_en;
   logic     ev;
   logic     sec;
   tap_sel_t tap;
   logic     flag_q, sqw_q, sec_q;

   assign hold = base_holds(base_sel_i);
   assign tap  = tap_of(base_sel_i, rate_sel_i);

   pdiv_prescale #(.PRE_HI_LOG2(PRE_HI_LOG2), .PRE_MID_LOG2(PRE_MID_LOG2)) pre_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .osc_tick_i(osc_tick_i),
      .base_sel_i(base_sel_i), .ref_en_o(ref_en));

   pdiv_chain #(.SEC_LOG2(SEC_LOG2)) chain_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .ref_en_i(ref_en),
      .tap_valid_i(tap.valid), .tap_idx_i(tap.idx), .event_o(ev), .sec_o(sec));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         sqw_q  <= 1'b0;
         sec_q  <= 1'b0;
      end else begin
         sec_q <= sec;
         if (ev)              flag_q <= 1'b1;
         else if (flag_clr_i) flag_q <= 1'b0;
         if (!sqw_en_i || !tap.valid) sqw_q <= 1'b0;
         else if (ev)                 sqw_q <= !sqw_q;
      end
   end

   assign per_flag_o = flag_q;
   assign irq_o      = flag_q && per_ie_i;
   assign sqw_o      = sqw_q;
   assign sec_tick_o = sec_q;

   assert_flag_from_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(per_flag_o) |-> $past(ev));
   assert_sqw_rise_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sqw_o) |-> $past(ev));
   assert_sqw_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sqw_en_i || rate_sel_i == 4'd0) |=> !sqw_o);
   assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (per_ie_i && per_flag_o));
   assert_no_event_code0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_sel_i == 4'd0) |-> !ev);

endmodule

// File: tb/periodic_divider_tb_top.sv
module periodic_divider_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc = 1'b1;
   logic [2:0] base = 3'd7;
   logic [3:0] rate = 4'd0;
   logic       ie = 1'b0, sqen = 1'b0, clr = 1'b0;
   logic       flag, irq, sqw, sec;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   periodic_divider dut_i (
      .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .base_sel_i(base),
      .rate_sel_i(rate), .per_ie_i(ie), .sqw_en_i(sqen), .flag_clr_i(clr),
      .per_flag_o(flag), .irq_o(irq), .sqw_o(sqw), .sec_tick_o(sec));

   typedef struct packed {
      logic [2:0]  b;
      logic [3:0]  c;
      logic [31:0] p;
   } vec_t;

   // R2, R3 and R4 periods in clock cycles, one oscillator tick per clock.
   localparam vec_t VECS [11] = '{
      '{3'd2, 4'd3,  32'd4},     '{3'd2, 4'd4,  32'd8},
      '{3'd2, 4'd6,  32'd32},    '{3'd2, 4'd15, 32'd16384},
      '{3'd2, 4'd1,  32'd128},   '{3'd2, 4'd2,  32'd256},
      '{3'd0, 4'd1,  32'd128},   '{3'd0, 4'd2,  32'd256},
      '{3'd1, 4'd1,  32'd32},    '{3'd1, 4'd3,  32'd128},
      '{3'd0, 4'd3,  32'd512}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold_then(input logic [2:0] b, input logic [3:0] c);
      @(negedge clk); base = 3'd7; clr = 1'b1;
      @(negedge clk); @(negedge clk);
      clr = 1'b0; base = b; rate = c;
   endtask

   // Count edges until sqw changes, limit-bounded.
   task automatic edges_to_sqw(output int n);
      logic prev = sqw;
      n = 0;
      for (int i = 0; i < 40000; i++) begin
         @(posedge clk); #1; n++;
         if (sqw != prev) return;
      end
   endtask

   initial begin : watchdog
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 flag", flag, 0); check("R1 irq", irq, 0);
      check("R1 sqw", sqw, 0);   check("R1 sec", sec, 0);

      // Vector table: first event after release, then one full period more.
      sqen = 1'b1;
      foreach (VECS[i]) begin
         hold_then(VECS[i].b, VECS[i].c);
         edges_to_sqw(n);
         check($sformatf("R2/R3/R4/R5 first b%0d c%0d", VECS[i].b, VECS[i].c), n, VECS[i].p);
         edges_to_sqw(n);
         check($sformatf("R9 period b%0d c%0d", VECS[i].b, VECS[i].c), n, VECS[i].p);
      end

      // R7/R8: flag sets with ie off, irq follows enable, clear works.
      sqen = 1'b0; ie = 1'b0;
      hold_then(3'd2, 4'd3);
      repeat (4) @(posedge clk); #1;
      check("R7 flag set ie off", flag, 1);
      check("R8 irq off", irq, 0);
      check("R9 sqw disabled", sqw, 0);
      @(negedge clk); ie = 1'b1; #1;
      check("R8 irq on", irq, 1);
      clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
      check("R7 flag cleared", flag, 0);
      check("R8 irq dropped", irq, 0);
      repeat (3) @(posedge clk); #1;
      check("R7 flag re-set", flag, 1);
      // Clear coinciding with event: event wins (next event 4 edges on).
      @(negedge clk); clr = 1'b1;
      repeat (4) @(posedge clk); #1;
      check("R7 set beats clear", flag, 1);
      @(negedge clk); clr = 1'b0;

      // R6: code 0 gives nothing.
      sqen = 1'b1;
      hold_then(3'd2, 4'd0);
      repeat (300) @(posedge clk); #1;
      check("R6 no flag", flag, 0);
      check("R9 sqw low code0", sqw, 0);

      // R5: hold bases produce nothing.
      hold_then(3'd6, 4'd3);
      repeat (200) @(posedge clk); #1;
      check("R5 hold 6 no flag", flag, 0);
      hold_then(3'd3, 4'd3);
      repeat (200) @(posedge clk); #1;
      check("R5 hold 3 no flag", flag, 0);

      // R11: oscillator idle stalls the chain.
      hold_then(3'd2, 4'd3);
      osc = 1'b0;
      repeat (50) @(posedge clk); #1;
      check("R11 no event without osc", flag, 0);
      @(negedge clk); osc = 1'b1;
      repeat (4) @(posedge clk); #1;
      check("R11 resumes", flag, 1);

      // R10: first second tick 32768 ticks after release, one cycle wide.
      hold_then(3'd2, 4'd15);
      n = 0;
      for (int i = 0; i < 40000; i++) begin
         @(posedge clk); #1; n++;
         if (sec) break;
      end
      check("R10 first second", n, 32768);
      @(posedge clk); #1;
      check("R10 pulse width", sec, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule